// File: doc/BRIEF.md
# Sticky Interrupt Cause Aggregator

This block sits in the remote endpoint of a serial link. It keeps six sticky interrupt-cause flags and one report-enable bit for each flag. From them it forms a single interrupt level that the link carries back to the master side.

Single-cycle event strobes from the surrounding logic set the flags: link timeout, two-wire timeout, link communication error, GPIO change, slave NACK and bus-reset-done. Once set, a flag stays set until software clears it through a small register port. Five of the flags clear on any write to the cause register. The GPIO-change flag ignores that write and clears only when software reads the GPIO monitor register.

The register port has an address, write data, a write strobe and a read strobe. Read data is registered. The interrupt output is a registered level.

Top module: `iac_aggregator`

## Requirements
- R1: The cause register is at address `CAUSE_ADDR` (default 0x01). It holds the flags in these bit positions: bit 0 link timeout, bit 1 two-wire timeout, bit 2 link communication error, bit 3 GPIO change, bit 4 slave NACK, bit 5 bus-reset-done. Bits 7:6 always read 0.
- R2: After a strobe on `cause_evt[i]`, flag i stays 1 until a clearing access for that flag occurs.
- R3: Any write to the cause register clears flags 5, 4, 2, 1 and 0, whatever the write data is.
- R4: A write to the cause register has no effect on flag 3.
- R5: A read of the GPIO monitor register at `GMON_ADDR` (default 0x41) clears flag 3 and returns the current value of `gpio_mon_in`. It leaves the other flags unchanged.
- R6: The enable register at `ENABLE_ADDR` (default 0x02) is writable in bits 5:0, using the same bit order as the cause register. Bits 7:6 read 0.
- R7: Synchronous reset clears all flags, all enable bits, the read data and the interrupt output.
- R8: `irq_out` is a level. On each clock edge it takes the OR of (flag AND enable) over all six bits, using the values held before that edge.
- R9: If an event strobe and a clearing access for the same flag occur in the same cycle, the flag ends up set.
- R10: A read of the cause register returns the raw flags, whatever the enable bits are.
- R11: `reg_rdata` is updated on the clock edge that samples `reg_rd` and is 0 in every cycle that follows an edge with no read. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cause_evt | input | 6 | One-cycle event strobes, one per cause bit |
| gpio_mon_in | input | 8 | GPIO input levels, returned when the monitor register is read |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Registered combined interrupt level |

## Verification
The assertions assume that every strobe is sampled on a rising edge and that each access lasts one cycle. They also assume that a read and a write may arrive in the same cycle, as independent operations.

The stimulus drives inputs only on falling edges and holds every access for exactly one cycle. It does issue reads and writes together, and it places events in the same cycle as clearing accesses, so the precedence rules are exercised inside the assumed protocol. A behavioural model in the bench follows every edge, and the outputs are compared against it in each cycle.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int CAUSE_N  = 6;
  localparam int GPIO_BIT = 3;
  // flags cleared by a write to the cause register
  localparam logic [CAUSE_N-1:0] WCLR_MASK = 6'b110111;
endpackage

// File: rtl/iac_sticky.sv
module iac_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // event has precedence over clearing
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/iac_irq_reduce.sv
module iac_irq_reduce #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flags_i & en_i);
  end

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((flags_i & en_i) == '0) |=> !irq_o);
  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(flags_i & en_i) != '0));
endmodule

// File: rtl/iac_aggregator.sv
module iac_aggregator #(
  parameter int          DATA_W      = 8,
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  CAUSE_ADDR  = 8'h01,
  parameter logic [7:0]  ENABLE_ADDR = 8'h02,
  parameter logic [7:0]  GMON_ADDR   = 8'h41
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        cause_evt,
  input  logic [DATA_W-1:0] gpio_mon_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  import iac_pkg::*;
  localparam int PAD_W = DATA_W - CAUSE_N;

  logic              hit_cause, hit_en, hit_gmon;
  logic              cause_wr, gmon_rd;
  logic [CAUSE_N-1:0] flags, en_q;

  assign hit_cause = (reg_addr == ADDR_W'(CAUSE_ADDR));
  assign hit_en    = (reg_addr == ADDR_W'(ENABLE_ADDR));
  assign hit_gmon  = (reg_addr == ADDR_W'(GMON_ADDR));
  assign cause_wr  = reg_wr & hit_cause;
  assign gmon_rd   = reg_rd & hit_gmon;

  for (genvar i = 0; i < CAUSE_N; i++) begin : g_flag
    logic clr;
    if (i == GPIO_BIT) begin : g_rdclr
      assign clr = gmon_rd;
    end else begin : g_wrclr
      assign clr = cause_wr;
    end
    iac_sticky u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (cause_evt[i]),
      .clr_i (clr),
      .q_o   (flags[i])
    );

    // R9
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
      cause_evt[i] |=> flags[i]);
    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !cause_wr && !gmon_rd) |=> flags[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)                  en_q <= '0;
    else if (reg_wr && hit_en) en_q <= reg_wdata[CAUSE_N-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !reg_rd) reg_rdata <= '0;
    else if (hit_cause) reg_rdata <= {{PAD_W{1'b0}}, flags};
    else if (hit_en)    reg_rdata <= {{PAD_W{1'b0}}, en_q};
    else if (hit_gmon)  reg_rdata <= gpio_mon_in;
    else                reg_rdata <= '0;
  end

  iac_irq_reduce #(.N(CAUSE_N)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .flags_i (flags),
    .en_i    (en_q),
    .irq_o   (irq_out)
  );

  // R3
  wr_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (cause_wr && cause_evt == '0) |=> ((flags & WCLR_MASK) == '0));
  // R4
  gpio_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (cause_wr && !gmon_rd && flags[GPIO_BIT]) |=> flags[GPIO_BIT]);
  // R5
  gmon_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (gmon_rd && !cause_evt[GPIO_BIT]) |=> !flags[GPIO_BIT]);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (hit_cause || hit_en)) |=> (reg_rdata[DATA_W-1:CAUSE_N] == '0));
  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));
endmodule

// File: tb/test_iac_aggregator.sv
module test_iac_aggregator;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cause_evt = '0;
  logic [7:0] gpio_mon_in = '0, reg_addr = '0, reg_wdata = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq_out;

  localparam logic [7:0] A_CAUSE = 8'h01, A_EN = 8'h02, A_GMON = 8'h41;

  int tests = 0, fails = 0;
  string cur_req = "R7";

  // behavioural reference
  logic [5:0] m_fl = '0, m_en = '0;
  logic [7:0] m_rd = '0;
  logic       m_irq = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  iac_aggregator i_iac_aggregator (
    .clk(clk), .rst(rst), .cause_evt(cause_evt), .gpio_mon_in(gpio_mon_in),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always @(posedge clk) begin
    logic [5:0] nf;
    if (rst) begin
      m_fl <= '0; m_en <= '0; m_rd <= '0; m_irq <= 1'b0;
    end else begin
      m_irq <= |(m_fl & m_en);
      nf = m_fl;
      if (reg_wr && reg_addr == A_CAUSE) nf = nf & 6'b001000;
      if (reg_rd && reg_addr == A_GMON)  nf[3] = 1'b0;
      nf = nf | cause_evt;
      m_fl <= nf;
      if (reg_wr && reg_addr == A_EN) m_en <= reg_wdata[5:0];
      if (!reg_rd)                 m_rd <= '0;
      else if (reg_addr == A_CAUSE) m_rd <= {2'b00, m_fl};
      else if (reg_addr == A_EN)    m_rd <= {2'b00, m_en};
      else if (reg_addr == A_GMON)  m_rd <= gpio_mon_in;
      else                          m_rd <= '0;
    end
  end

  always @(negedge clk) begin
    tests++;
    if (reg_rdata !== m_rd) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h", cur_req, reg_rdata, m_rd);
    end
    tests++;
    if (irq_out !== m_irq) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", cur_req, irq_out, m_irq);
    end
  end

  task automatic cyc(input logic [5:0] ev, input logic wr, input logic rd,
                     input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cause_evt = ev; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    cause_evt = '0; reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  initial begin
    #4000000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R7"; cyc(0, 0, 1, A_CAUSE, 0); cyc(0, 0, 1, A_EN, 0);
    cur_req = "R2"; cyc(6'h3F, 0, 0, 0, 0); repeat (3) cyc(0, 0, 0, 0, 0);
    cur_req = "R10"; cyc(0, 0, 1, A_CAUSE, 0);
    cur_req = "R3"; cyc(0, 1, 0, A_CAUSE, 8'h00); cyc(0, 0, 1, A_CAUSE, 0);
    cur_req = "R4"; cyc(0, 1, 0, A_CAUSE, 8'hFF); cyc(0, 0, 1, A_CAUSE, 0);
    cur_req = "R5"; gpio_mon_in = 8'hA5; cyc(0, 0, 1, A_GMON, 0); cyc(0, 0, 1, A_CAUSE, 0);
    cur_req = "R6"; cyc(0, 1, 0, A_EN, 8'hFF); cyc(0, 0, 1, A_EN, 0);
    cur_req = "R8"; cyc(6'h04, 0, 0, 0, 0); repeat (2) cyc(0, 0, 0, 0, 0);
    cyc(0, 1, 0, A_EN, 8'h08); cyc(0, 0, 0, 0, 0); cyc(6'h08, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    cur_req = "R9"; cyc(6'h01, 1, 0, A_CAUSE, 8'h55); cyc(6'h08, 0, 1, A_GMON, 0);
    cyc(0, 0, 1, A_CAUSE, 0);
    cur_req = "R11"; cyc(0, 0, 1, 8'h77, 0); cyc(0, 0, 0, 0, 0);
    cur_req = "R1"; cyc(6'h21, 0, 0, 0, 0); cyc(0, 0, 1, A_CAUSE, 0);
    cur_req = "R8";
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      gpio_mon_in = 8'($urandom);
      cyc(($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h00,
          op[0], op[1],
          (op == 0) ? 8'h00 : (($urandom_range(0, 3) == 0) ? A_EN :
                               ($urandom_range(0, 1) == 0) ? A_CAUSE : A_GMON),
          8'($urandom));
    end
    cur_req = "R7"; rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0; cyc(0, 0, 1, A_EN, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule